// File: doc/BRIEF.md
# Stereo Audio Serial Port with Selectable Alignment

This block moves two-channel audio between a parallel sample interface and a three-wire serial link made of a bit clock, a channel-select clock and one data line in each direction. Transmit and receive share the framing, so playback and capture run at the same time. Each channel owns a fixed slot of `SLOT` bit clocks. The channel-select clock is low during the left slot and high during the right slot, so it toggles once per slot and completes one period per sample.

The port can drive the link clocks itself or follow clocks from the far end. When it drives them, the bit clock is divided from the system clock by a programmable ratio. When it follows, both external clocks are brought into the system clock domain through two-flop synchronizers and used through edge detection. A format input places the sample inside its slot in one of three ways: one bit after the channel switch, at the channel switch, or flush against the end of the slot. The active sample width is programmable. Bits outside the sample are sent as zero and dropped on receive.

Samples pass through a one-pair transmit buffer under a valid/ready handshake. Captured pairs come out under a valid/ready handshake from a one-pair output register.

Top module: `aud_serial_port`

## Requirements
- R1: While reset is held, `bclk_o` and `sdo` are 0, `tx_ready` is 1 and `rx_valid` is 0.
- R2: As clock driver (`cfg_master`=1), each level of `bclk_o` lasts `cfg_div`+1 system clock cycles.
- R3: As clock driver, `lrclk_o` changes only in the cycle where `bclk_o` falls, is low for the left channel and high for the right, and each slot spans 32 bit clocks (`SLOT`).
- R4: With `cfg_fmt`=0, the sample MSB is sent in the second bit period of the slot, which is slot position 1 where position 0 starts at the channel-select change.
- R5: With `cfg_fmt`=1, the sample MSB is sent at slot position 0.
- R6: With `cfg_fmt`=2, the MSB is sent at position `SLOT`-`cfg_width`, so the LSB falls on the last position of the slot. Widths from 1 to `SLOT`-1 are supported in every format.
- R7: Every slot position outside the sample window is sent as 0. `sdo` changes only where the bit clock falls.
- R8: `sdi` is sampled on rising bit-clock edges within the same window. After the right channel's LSB, `rx_left`/`rx_right` carry the pair right-aligned with zero upper bits, and `rx_valid` rises.
- R9: A pair is accepted when `tx_valid` and `tx_ready` are both 1. `tx_ready` then stays 0 until the next left slot starts, where the pair is taken for sending. A frame that starts with an empty buffer sends zeros in both slots.
- R10: `rx_valid` stays 1 until a cycle with `rx_ready`=1, and falls after that cycle.
- R11: As clock follower (`cfg_master`=0), framing, transmit and receive follow `bclk_i`/`lrclk_i`, and `bclk_o` and `lrclk_o` are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_master | input | 1 | 1: generate link clocks, 0: follow external clocks |
| cfg_fmt | input | 2 | Alignment: 0 one-bit delay, 1 at switch, 2 end of slot |
| cfg_width | input | $clog2(SLOT) | Sample width in bits, 1 to SLOT-1 |
| cfg_div | input | DIVW | Bit clock half period minus one, in system cycles |
| bclk_i | input | 1 | External bit clock (follower) |
| lrclk_i | input | 1 | External channel-select clock (follower) |
| sdi | input | 1 | Serial receive data |
| bclk_o | output | 1 | Generated bit clock |
| lrclk_o | output | 1 | Generated channel-select clock |
| sdo | output | 1 | Serial transmit data |
| tx_valid | input | 1 | Transmit pair offered |
| tx_ready | output | 1 | Transmit buffer free |
| tx_left | input | SLOT | Left transmit sample, right-aligned |
| tx_right | input | SLOT | Right transmit sample, right-aligned |
| rx_valid | output | 1 | Received pair available |
| rx_ready | input | 1 | Received pair taken |
| rx_left | output | SLOT | Left received sample, right-aligned |
| rx_right | output | SLOT | Right received sample, right-aligned |

## Verification
The bench uses the default `SLOT`=32 and `DIVW`=8 and changes the run-time configuration between resets. Divider values 0, 1 and 2 cover the fastest bit clock, where a bit lasts two system cycles, as well as slower ratios. Widths of 1 and 31 place the sample window at both edges of the slot in every format. Follower runs use an external bit clock of sixteen system cycles per bit, which leaves room for the synchronizer delay on both data lines.

// File: rtl/aud_serial_port.sv
module aud_serial_port #(
  parameter int SLOT = 32,
  parameter int DIVW = 8,
  localparam int PW = $clog2(SLOT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_master,
  input  logic [1:0]      cfg_fmt,
  input  logic [PW-1:0]   cfg_width,
  input  logic [DIVW-1:0] cfg_div,
  input  logic            bclk_i,
  input  logic            lrclk_i,
  input  logic            sdi,
  output logic            bclk_o,
  output logic            lrclk_o,
  output logic            sdo,
  input  logic            tx_valid,
  output logic            tx_ready,
  input  logic [SLOT-1:0] tx_left,
  input  logic [SLOT-1:0] tx_right,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic [SLOT-1:0] rx_left,
  output logic [SLOT-1:0] rx_right
);

  logic [2:0]      bsy;
  logic [1:0]      lsy, dsy;
  logic [DIVW-1:0] divc;
  logic            ch, lr_smp, buf_full;
  logic [PW-1:0]   pos;
  logic [SLOT-1:0] buf_l, buf_r, act_l, act_r, acc_l, acc_r;

  function automatic logic in_win(input logic [PW-1:0] p, input logic [PW-1:0] o,
                                  input logic [PW-1:0] w);
    return (p >= o) && ((p - o) < w);
  endfunction

  wire tick    = cfg_master && (divc == cfg_div);
  wire fall_ev = cfg_master ? (tick & bclk_o)  : (bsy[2] & ~bsy[1]);
  wire rise_ev = cfg_master ? (tick & ~bclk_o) : (~bsy[2] & bsy[1]);
  wire rx_bit  = cfg_master ? sdi : dsy[1];
  wire resync  = !cfg_master && (lr_smp != ch);

  wire [PW:0]   nxt      = resync ? {lr_smp, PW'(1)} : ({ch, pos} + 1'b1);
  wire          nch      = nxt[PW];
  wire [PW-1:0] npos     = nxt[PW-1:0];
  wire          frame_go = fall_ev && (nxt == '0);

  wire [PW-1:0] off = (cfg_fmt == 2'd2) ? ({PW{1'b0}} - cfg_width) :
                      (cfg_fmt == 2'd1) ? {PW{1'b0}} : PW'(1);

  wire [SLOT-1:0] nl      = frame_go ? (buf_full ? buf_l : '0) : act_l;
  wire [SLOT-1:0] nr      = frame_go ? (buf_full ? buf_r : '0) : act_r;
  wire [SLOT-1:0] tsmp    = nch ? nr : nl;
  wire [PW-1:0]   tk      = npos - off;
  wire [PW-1:0]   tidx    = cfg_width - 1'b1 - tk;
  wire            sdo_nxt = in_win(npos, off, cfg_width) & tsmp[tidx];

  wire [PW-1:0]   rk      = pos - off;
  wire            rx_hit  = rise_ev && in_win(pos, off, cfg_width);
  wire [SLOT-1:0] acc_src = ch ? acc_r : acc_l;
  wire [SLOT-1:0] acc_nxt = (rk == '0) ? {{(SLOT-1){1'b0}}, rx_bit} : {acc_src[SLOT-2:0], rx_bit};
  wire            rx_done = rx_hit && ch && (rk == cfg_width - 1'b1);

  assign tx_ready = ~buf_full;
  assign lrclk_o  = cfg_master & ch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsy <= '0;
      lsy <= '0;
      dsy <= '0;
    end else begin
      bsy <= {bsy[1:0], bclk_i};
      lsy <= {lsy[0], lrclk_i};
      dsy <= {dsy[0], sdi};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !cfg_master) begin
      divc   <= '0;
      bclk_o <= 1'b0;
    end else if (tick) begin
      divc   <= '0;
      bclk_o <= ~bclk_o;
    end else begin
      divc <= divc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch     <= 1'b1;
      pos    <= '1;
      lr_smp <= 1'b1;
      sdo    <= 1'b0;
      act_l  <= '0;
      act_r  <= '0;
    end else begin
      if (rise_ev) lr_smp <= lsy[1];
      if (fall_ev) begin
        ch    <= nch;
        pos   <= npos;
        sdo   <= sdo_nxt;
        act_l <= nl;
        act_r <= nr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      buf_l    <= '0;
      buf_r    <= '0;
    end else if (tx_valid && !buf_full) begin
      buf_full <= 1'b1;
      buf_l    <= tx_left;
      buf_r    <= tx_right;
    end else if (frame_go) begin
      buf_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_l    <= '0;
      acc_r    <= '0;
      rx_left  <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (rx_hit) begin
        if (ch) acc_r <= acc_nxt;
        else    acc_l <= acc_nxt;
      end
      if (rx_done) begin
        rx_left  <= acc_l;
        rx_right <= acc_nxt;
        rx_valid <= 1'b1;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/aud_serial_port_chk.sv
module aud_serial_port_chk #(
  parameter int DIVW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_master,
  input logic [DIVW-1:0] cfg_div,
  input logic            bclk_o,
  input logic            lrclk_o,
  input logic            sdo,
  input logic            tx_valid,
  input logic            tx_ready,
  input logic            rx_valid,
  input logic            rx_ready
);

  logic [DIVW-1:0] hc;
  logic            pb, seen;

  always_ff @(posedge clk) begin
    if (!rst_n || !cfg_master) begin
      hc   <= '0;
      pb   <= 1'b0;
      seen <= 1'b0;
    end else begin
      pb <= bclk_o;
      if (bclk_o != pb) begin
        hc   <= '0;
        seen <= 1'b1;
      end else begin
        hc <= hc + 1'b1;
      end
    end
  end

  assert_half_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && seen && (bclk_o != pb)) |-> (hc == cfg_div));

  assert_lr_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !$stable(lrclk_o)) |-> $fell(bclk_o));

  assert_sdo_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !$stable(sdo)) |-> $fell(bclk_o));

  assert_buffer_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  assert_follower_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |-> (!bclk_o && !lrclk_o));

endmodule

bind aud_serial_port aud_serial_port_chk #(.DIVW(DIVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_div(cfg_div),
  .bclk_o(bclk_o), .lrclk_o(lrclk_o), .sdo(sdo), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready)
);

// File: tb/aud_serial_port_tb.sv
module aud_serial_port_tb;
  logic        clk = 0, rst_n = 0;
  logic        cfg_master = 1;
  logic [1:0]  cfg_fmt = 0;
  logic [4:0]  cfg_width = 5'd16;
  logic [7:0]  cfg_div = 8'd1;
  logic        bclk_i = 0, lrclk_i = 0, sdi = 0;
  logic        bclk_o, lrclk_o, sdo, tx_ready, rx_valid;
  logic        tx_valid = 0, rx_ready = 1;
  logic [31:0] tx_left = 0, tx_right = 0, rx_left, rx_right;

  aud_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_fmt(cfg_fmt),
    .cfg_width(cfg_width), .cfg_div(cfg_div), .bclk_i(bclk_i), .lrclk_i(lrclk_i),
    .sdi(sdi), .bclk_o(bclk_o), .lrclk_o(lrclk_o), .sdo(sdo), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_left(tx_left), .tx_right(tx_right), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_left(rx_left), .rx_right(rx_right)
  );

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  logic ext_en = 0, rx_chk_en = 1;
  logic [31:0] exp_l [16], exp_r [16], rxs_l [64], rxs_r [64];
  int ntx = 0, ti = 0, ri = 0, nrx = 0, lstarts = 0;
  int mpos = 0, dpos = 0, cyc = 0;
  logic pbk = 0, plr_r = 0, plr_f = 0, slot_arm = 0, frm_arm = 0, per_arm = 0, lseen = 0;
  logic [31:0] sv = 0, lobs = 0, cur_l = 0, cur_r = 0;

  wire bclk_w = cfg_master ? bclk_o : bclk_i;
  wire lr_w   = cfg_master ? lrclk_o : lrclk_i;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int offset_of(int fmt, int w);
    if (fmt == 2) return 32 - w;
    if (fmt == 1) return 0;
    return 1;
  endfunction

  function automatic bit exp_bit(int fmt, int w, logic [31:0] s, int p);
    int off, k;
    off = offset_of(fmt, w);
    k = p - off;
    if (p >= off && k < w) return s[w-1-k];
    return 1'b0;
  endfunction

  function automatic logic [31:0] dec_slot(int fmt, int w, logic [31:0] v);
    logic [31:0] r;
    int off;
    r = 0;
    off = offset_of(fmt, w);
    for (int k = 0; k < w; k++) r[w-1-k] = v[off+k];
    return r;
  endfunction

  function automatic logic [31:0] enc_slot(int fmt, int w, logic [31:0] s);
    logic [31:0] r;
    for (int p = 0; p < 32; p++) r[p] = exp_bit(fmt, w, s, p);
    return r;
  endfunction

  function automatic string fmt_req(int fmt);
    if (fmt == 2) return "R6";
    if (fmt == 1) return "R5";
    return "R4";
  endfunction

  task automatic end_slot(input logic chn);
    logic [31:0] d;
    d = dec_slot(cfg_fmt, cfg_width, sv);
    chk(mpos == 32, "R3 slot length", mpos, 32);
    chk(sv == enc_slot(cfg_fmt, cfg_width, d), "R7 padding zero", sv, enc_slot(cfg_fmt, cfg_width, d));
    if (!chn) begin
      lobs = d;
      lseen = 1;
    end else if (lseen) begin
      lseen = 0;
      if (lobs != 0 || d != 0) begin
        if (ti < ntx) begin
          chk(lobs == exp_l[ti], fmt_req(cfg_fmt), lobs, exp_l[ti]);
          chk(d == exp_r[ti], fmt_req(cfg_fmt), d, exp_r[ti]);
        end else begin
          chk(0, "R9 underrun frame not zero", d, 0);
        end
        ti++;
      end
    end
  endtask

  initial begin
    int ediv;
    logic [5:0] ebit;
    ediv = 0;
    ebit = 0;
    forever begin
      @(posedge clk);
      #1;
      if (ext_en) begin
        ediv++;
        if (ediv == 8) begin
          ediv = 0;
          bclk_i = ~bclk_i;
          if (!bclk_i) begin
            ebit = ebit + 1'b1;
            lrclk_i = ebit[5];
          end
        end
      end else begin
        ediv = 0;
        ebit = 0;
        bclk_i = 0;
        lrclk_i = 0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        pbk = 0; plr_r = lr_w; plr_f = lr_w; mpos = 0; sv = 0; lstarts = 0;
        ti = 0; ri = 0; nrx = 0; cur_l = 0; cur_r = 0; frm_arm = 0; slot_arm = 0;
        per_arm = 0; cyc = 0; lseen = 0; lobs = 0; dpos = 0; sdi = 0;
      end else begin
        cyc++;
        if (!pbk && bclk_w) begin
          if (cfg_master && per_arm) chk(cyc == 2 * (cfg_div + 1), "R2 bit clock period", cyc, 2 * (cfg_div + 1));
          per_arm = 1;
          cyc = 0;
          if (lr_w != plr_r) begin
            if (slot_arm) end_slot(plr_r);
            slot_arm = (lstarts >= 2);
            mpos = 0;
            sv = 0;
            plr_r = lr_w;
          end
          if (mpos < 32) sv[mpos] = sdo;
          mpos++;
        end
        if (pbk && !bclk_w) begin
          if (lr_w != plr_f) begin
            dpos = 0;
            plr_f = lr_w;
            if (!lr_w) begin
              lstarts++;
              frm_arm = (lstarts >= 2);
              if (frm_arm) begin
                cur_l = rxs_l[ri % 64];
                cur_r = rxs_r[ri % 64];
                ri++;
              end
            end
          end else begin
            dpos++;
          end
          sdi = exp_bit(cfg_fmt, cfg_width, lr_w ? cur_r : cur_l, dpos);
        end
        if (rx_valid && rx_ready && rx_chk_en && frm_arm) begin
          chk(rx_left == cur_l, "R8 left capture", rx_left, cur_l);
          chk(rx_right == cur_r, "R8 right capture", rx_right, cur_r);
          nrx++;
        end
        pbk = bclk_w;
      end
    end
  end

  task automatic push(input logic [31:0] l, input logic [31:0] r);
    @(negedge clk);
    tx_left = l;
    tx_right = r;
    tx_valid = 1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 0;
    chk(tx_ready == 0, "R9 ready drops", tx_ready, 0);
  endtask

  task automatic run_phase(input bit mst, input int fmt, input int w, input int div, input int n, input bit hold);
    logic [31:0] mask;
    int frame, t;
    mask = (32'h1 << w) - 1;
    frame = mst ? 128 * (div + 1) : 1024;
    @(negedge clk);
    rst_n = 0;
    ext_en = 0;
    cfg_master = mst;
    cfg_fmt = 2'(fmt);
    cfg_width = 5'(w);
    cfg_div = 8'(div);
    for (int i = 0; i < 64; i++) begin
      rxs_l[i] = $urandom & mask;
      rxs_r[i] = $urandom & mask;
    end
    repeat (3) @(negedge clk);
    chk(bclk_o == 0 && sdo == 0, "R1 reset outputs", {bclk_o, sdo}, 0);
    chk(tx_ready == 1 && rx_valid == 0, "R1 reset handshake", {tx_ready, rx_valid}, 2);
    ntx = n;
    for (int i = 0; i < n; i++) begin
      exp_l[i] = $urandom & mask;
      exp_r[i] = $urandom & mask;
      if (exp_l[i] == 0 && exp_r[i] == 0) exp_l[i] = 1;
    end
    if (w == 31 && n > 0) begin
      exp_l[0] = mask;
      exp_r[0] = 32'h4000_0001;
    end
    rst_n = 1;
    ext_en = !mst;
    t = 0;
    while (lstarts < 2 && t < 20 * frame) begin
      @(negedge clk);
      t++;
    end
    for (int i = 0; i < n; i++) push(exp_l[i], exp_r[i]);
    t = 0;
    while (ti < n && t < 20 * frame) begin
      @(negedge clk);
      t++;
    end
    repeat (3 * frame) @(negedge clk);
    chk(ti == n, mst ? "R9 all pairs sent" : "R11 follower pairs sent", ti, n);
    chk(nrx >= 2, mst ? "R8 captures seen" : "R11 follower captures", nrx, 2);
    if (!mst) chk(!bclk_o && !lrclk_o, "R11 outputs quiet", {bclk_o, lrclk_o}, 0);
    if (hold) begin
      rx_chk_en = 0;
      rx_ready = 0;
      t = 0;
      while (!rx_valid && t < 4 * frame) begin
        @(negedge clk);
        t++;
      end
      repeat (2 * frame) @(negedge clk);
      chk(rx_valid == 1, "R10 valid held", rx_valid, 1);
      rx_ready = 1;
      @(negedge clk);
      chk(rx_valid == 0, "R10 valid released", rx_valid, 0);
      rx_chk_en = 1;
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    run_phase(1, 0, 16, 1, 6, 1);
    run_phase(1, 1, 24, 0, 6, 0);
    run_phase(1, 2, 20, 2, 6, 0);
    run_phase(1, 2, 31, 1, 4, 0);
    run_phase(1, 1, 1, 1, 4, 0);
    run_phase(1, 0, 31, 0, 4, 0);
    run_phase(0, 0, 24, 0, 4, 0);
    run_phase(0, 2, 16, 0, 4, 0);
    run_phase(0, 1, 8, 0, 3, 0);
    summary();
    $finish;
  end
endmodule